// File: doc/BRIEF.md
# Float-to-Integer Converter

The block turns one IEEE 754 binary32 or binary64 operand into a signed 32-bit or 64-bit integer. The operand, its format and the result width are given with each request. The rounding direction comes from the operation code. Ceiling, floor and truncate each fix a direction. Round uses nearest with ties to even. Convert takes the direction from a separate rounding-mode input.

Operands that cannot be represented are NaN, infinities and finite values whose rounded magnitude falls outside the result range. A run-time mode bit decides what these produce. In 2008 mode a NaN gives zero and an overflow saturates toward its own sign. In legacy mode every such case gives the largest positive integer. Both modes raise an invalid-operation flag for these cases. An inexact flag reports that a fraction was dropped from a representable result.

Each request is qualified by `valid_i`. The result and flags appear one clock later with `valid_o`, and they hold until the next accepted request.

Top module: `f2i_convert`

## Requirements
- R1: With `dbl_i`=0 the operand is binary32 in `operand_i[31:0]`, and with `dbl_i`=1 it is binary64 in `operand_i[63:0]`. With `long_i`=1 the result is 64 bits. With `long_i`=0 the result is 32 bits, sign-extended onto `result_o[63:32]`.
- R2: `op_i` encodings 0 (ceiling), 1 (floor) and 3 (truncate) round toward +infinity, toward -infinity and toward zero. Codes 5 to 7 act as truncate.
- R3: `op_i`=2 rounds to nearest with ties to even. `op_i`=4 uses `rmode_i`, where 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity.
- R4: With `nan2008_i`=1, a NaN operand gives a result of 0.
- R5: With `nan2008_i`=1, an operand whose rounded value is above the largest integer of the result width gives that largest integer, and this includes +infinity. One below the smallest integer gives the smallest integer, and this includes -infinity. The smallest integer itself (-2^31 or -2^63) is in range and exact.
- R6: With `nan2008_i`=0, a NaN and an out-of-range operand of either sign both give the largest positive integer of the result width (0x7FFFFFFF sign-extended, or 0x7FFFFFFFFFFFFFFF).
- R7: `invalid_o` is 1 exactly for NaN and out-of-range operands, in both modes, and `inexact_o` is 0 whenever `invalid_o` is 1. Range is judged after rounding.
- R8: For an in-range operand, `inexact_o` is 1 when rounding discarded a nonzero fraction, subnormals included, and 0 for exact values. Signed zero converts to 0.
- R9: A request with `valid_i`=1 gives `valid_o`=1 on the next cycle. While `valid_i`=0, `valid_o` is 0 and the result and flags keep their last values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request qualifier |
| operand_i | input | 64 | Floating-point operand |
| dbl_i | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| long_i | input | 1 | 1: 64-bit result, 0: 32-bit sign-extended |
| op_i | input | 3 | 0 ceil, 1 floor, 2 round, 3 trunc, 4 convert by rmode_i |
| rmode_i | input | 2 | 0 nearest-even, 1 zero, 2 +inf, 3 -inf |
| nan2008_i | input | 1 | 1: 2008 handling, 0: legacy saturation |
| valid_o | output | 1 | Result qualifier, one cycle after valid_i |
| result_o | output | 64 | Integer result |
| invalid_o | output | 1 | NaN or out-of-range operand |
| inexact_o | output | 1 | Fraction discarded from an in-range result |

## Verification
The bench aims at the rounding edges: halfway values of both parities, negative operands under directed rounding, and subnormals that round to ±1. A design that rounds ties away from zero, or that applies a direction to the magnitude and not to the signed value, would return a result one off. It also drives the range limits. These are -2^31 and -2^63, which must be exact and in range, and the value 2^31-0.5, which overflows a word only after rounding to nearest. A design that checks range before rounding, or that uses a symmetric limit, would pass an out-of-range result or flag a valid one. NaN and infinities of both signs go through both mode settings and both result widths, so that a swapped legacy/2008 case or an unextended word shows up as a wrong saturation value.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_BIAS   = 127;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_BIAS   = 1023;
  localparam int OPND_W     = 64;
  localparam int INT_W      = 64;
  localparam int WORD_W     = 32;
  localparam int MANT_W     = DBL_FRAC_W + 1;
  localparam int EXP_W      = 13;
  localparam int EXT_W      = 2 * INT_W;        // INT_W integer + INT_W fraction bits
  localparam int SH_W       = $clog2(EXT_W);
  localparam int SH_OFF     = INT_W - DBL_FRAC_W;

  typedef enum logic [2:0] {
    OP_CEIL  = 3'd0,
    OP_FLOOR = 3'd1,
    OP_ROUND = 3'd2,
    OP_TRUNC = 3'd3,
    OP_CVT   = 3'd4
  } f2i_op_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } f2i_rm_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic signed [EXP_W-1:0] expo;   // unbiased, value = mant * 2^(expo - DBL_FRAC_W)
    logic [MANT_W-1:0]       mant;
  } f2i_unp_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [OPND_W-1:0] operand_i,
  input  logic              dbl_i,
  output f2i_unp_t          unp_o
);
  logic [SGL_EXP_W-1:0]  s_exp;
  logic [SGL_FRAC_W-1:0] s_frac;
  logic [DBL_EXP_W-1:0]  d_exp;
  logic [DBL_FRAC_W-1:0] d_frac;
  logic                  s_sub, d_sub;

  assign s_exp  = operand_i[SGL_FRAC_W +: SGL_EXP_W];
  assign s_frac = operand_i[SGL_FRAC_W-1:0];
  assign d_exp  = operand_i[DBL_FRAC_W +: DBL_EXP_W];
  assign d_frac = operand_i[DBL_FRAC_W-1:0];
  assign s_sub  = ~|s_exp;
  assign d_sub  = ~|d_exp;

  always_comb begin
    if (dbl_i) begin
      unp_o.sign   = operand_i[OPND_W-1];
      unp_o.is_nan = (&d_exp) & (|d_frac);
      unp_o.is_inf = (&d_exp) & ~(|d_frac);
      unp_o.expo   = d_sub ? EXP_W'(1 - DBL_BIAS)
                           : EXP_W'(d_exp) - EXP_W'(DBL_BIAS);
      unp_o.mant   = {~d_sub, d_frac};
    end else begin
      unp_o.sign   = operand_i[SGL_FRAC_W+SGL_EXP_W];
      unp_o.is_nan = (&s_exp) & (|s_frac);
      unp_o.is_inf = (&s_exp) & ~(|s_frac);
      unp_o.expo   = s_sub ? EXP_W'(1 - SGL_BIAS)
                           : EXP_W'(s_exp) - EXP_W'(SGL_BIAS);
      // left-align single fraction in the double-width mantissa
      unp_o.mant   = {~s_sub, s_frac, {(MANT_W-1-SGL_FRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  f2i_unp_t         unp_i,
  input  f2i_rm_e          rm_i,
  output logic [INT_W:0]   mag_o,
  output logic             big_o,
  output logic             inexact_o
);
  localparam logic signed [EXP_W-1:0] E_MAX  = EXP_W'(INT_W - 1);
  localparam logic signed [EXP_W-1:0] E_MIN  = EXP_W'(-INT_W);
  localparam logic signed [EXP_W-1:0] E_LSHF = EXP_W'(-SH_OFF);

  logic [EXT_W-1:0]  ext;
  logic              lost, tiny;
  logic [SH_W-1:0]   shl, shr;
  logic [INT_W-1:0]  int_part;
  logic              rnd, stk, inc;

  assign shl = SH_W'(unp_i.expo + EXP_W'(SH_OFF));
  assign shr = SH_W'(-(unp_i.expo + EXP_W'(SH_OFF)));

  // place value on a fixed point grid: INT_W integer bits above INT_W fraction bits
  always_comb begin
    ext   = '0;
    lost  = 1'b0;
    tiny  = 1'b0;
    big_o = 1'b0;
    if (unp_i.expo > E_MAX) begin
      big_o = 1'b1;
    end else if (unp_i.expo < E_MIN) begin
      tiny = 1'b1;
    end else if (unp_i.expo >= E_LSHF) begin
      ext = EXT_W'(unp_i.mant) << shl;
    end else begin
      ext  = EXT_W'(unp_i.mant >> shr);
      lost = |(unp_i.mant & ((MANT_W'(1) << shr) - MANT_W'(1)));
    end
  end

  assign int_part = ext[EXT_W-1:INT_W];
  assign rnd      = ext[INT_W-1];
  assign stk      = (|ext[INT_W-2:0]) | lost | (tiny & (|unp_i.mant));

  always_comb begin
    unique case (rm_i)
      RM_NEAR: inc = rnd & (stk | int_part[0]);
      RM_UP:   inc = ~unp_i.sign & (rnd | stk);
      RM_DOWN: inc =  unp_i.sign & (rnd | stk);
      default: inc = 1'b0;
    endcase
  end

  assign mag_o     = {1'b0, int_part} + (INT_W+1)'(inc);
  assign inexact_o = rnd | stk;
endmodule

// File: rtl/f2i_sat.sv
module f2i_sat
  import f2i_pkg::*;
(
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             inf_i,
  input  logic             big_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             inexact_i,
  input  logic             long_i,
  input  logic             nan2008_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] MAX_L = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_L = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_W = {{(INT_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_W = {{(INT_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic [INT_W-1:0] max_v, min_v, sgn_v, fit_v;
  logic [INT_W:0]   lim_pos, lim_neg;
  logic             ovf;

  assign max_v   = long_i ? MAX_L : MAX_W;
  assign min_v   = long_i ? MIN_L : MIN_W;
  assign lim_pos = {1'b0, max_v};
  assign lim_neg = {1'b0, (~min_v) + INT_W'(1)};   // magnitude of the smallest integer

  assign ovf = ~nan_i & (big_i | inf_i | (sign_i ? (mag_i > lim_neg) : (mag_i > lim_pos)));

  assign sgn_v = sign_i ? (~mag_i[INT_W-1:0] + INT_W'(1)) : mag_i[INT_W-1:0];
  assign fit_v = long_i ? sgn_v : {{(INT_W-WORD_W){sgn_v[WORD_W-1]}}, sgn_v[WORD_W-1:0]};

  always_comb begin
    if (nan_i)      result_o = nan2008_i ? '0 : max_v;
    else if (ovf)   result_o = (nan2008_i && sign_i) ? min_v : max_v;
    else            result_o = fit_v;
  end

  assign invalid_o = nan_i | ovf;
  assign inexact_o = ~invalid_o & inexact_i;
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPND_W-1:0] operand_i,
  input  logic              dbl_i,
  input  logic              long_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        rmode_i,
  input  logic              nan2008_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  result_o,
  output logic              invalid_o,
  output logic              inexact_o
);
  f2i_unp_t         unp;
  f2i_rm_e          rm;
  logic [INT_W:0]   mag;
  logic             big, inx_raw;
  logic [INT_W-1:0] res_c;
  logic             inv_c, inx_c;

  always_comb begin
    unique case (f2i_op_e'(op_i))
      OP_CEIL:  rm = RM_UP;
      OP_FLOOR: rm = RM_DOWN;
      OP_ROUND: rm = RM_NEAR;
      OP_CVT:   rm = f2i_rm_e'(rmode_i);
      default:  rm = RM_ZERO;
    endcase
  end

  f2i_unpack u_unpack (
    .operand_i (operand_i),
    .dbl_i     (dbl_i),
    .unp_o     (unp)
  );

  f2i_round u_round (
    .unp_i     (unp),
    .rm_i      (rm),
    .mag_o     (mag),
    .big_o     (big),
    .inexact_o (inx_raw)
  );

  f2i_sat u_sat (
    .sign_i    (unp.sign),
    .nan_i     (unp.is_nan),
    .inf_i     (unp.is_inf),
    .big_i     (big),
    .mag_i     (mag),
    .inexact_i (inx_raw),
    .long_i    (long_i),
    .nan2008_i (nan2008_i),
    .result_o  (res_c),
    .invalid_o (inv_c),
    .inexact_o (inx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_c;
        invalid_o <= inv_c;
        inexact_o <= inx_c;
      end
    end
  end

  p_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));

  p_nan_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && nan2008_i && unp.is_nan) |=> (result_o == '0 && invalid_o));

  p_legacy_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !nan2008_i && (unp.is_nan || unp.is_inf)) |=>
      (result_o == ($past(long_i) ? {1'b0, {(INT_W-1){1'b1}}}
                                  : INT_W'({(WORD_W-1){1'b1}}))));

  p_word_sext_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !long_i) |=> (result_o[INT_W-1:WORD_W] == {(INT_W-WORD_W){result_o[WORD_W-1]}}));

  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));

  p_inf_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unp.is_inf) |=> invalid_o);
endmodule

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        dbl_i = 1'b0, long_i = 1'b0, nan2008_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        valid_o, invalid_o, inexact_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        inx;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  localparam logic [63:0] MAXW = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] MINW = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] MAXL = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINL = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_2P5   = 64'h4004_0000_0000_0000;
  localparam logic [63:0] D_M2P5  = 64'hC004_0000_0000_0000;
  localparam logic [63:0] D_1P5   = 64'h3FF8_0000_0000_0000;
  localparam logic [63:0] D_M1P5  = 64'hBFF8_0000_0000_0000;
  localparam logic [63:0] D_0P5   = 64'h3FE0_0000_0000_0000;
  localparam logic [63:0] D_M0P5  = 64'hBFE0_0000_0000_0000;
  localparam logic [63:0] D_100   = 64'h4059_0000_0000_0000;
  localparam logic [63:0] D_P31   = 64'h41E0_0000_0000_0000;
  localparam logic [63:0] D_M31   = 64'hC1E0_0000_0000_0000;
  localparam logic [63:0] D_P63   = 64'h43E0_0000_0000_0000;
  localparam logic [63:0] D_M63   = 64'hC3E0_0000_0000_0000;
  localparam logic [63:0] D_EDGE  = 64'h41DF_FFFF_FFE0_0000;  // 2^31 - 0.5
  localparam logic [63:0] D_PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] D_MINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_NAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_MZERO = 64'h8000_0000_0000_0000;

  f2i_convert u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .operand_i (operand_i),
    .dbl_i     (dbl_i),
    .long_i    (long_i),
    .op_i      (op_i),
    .rmode_i   (rmode_i),
    .nan2008_i (nan2008_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
  );

  always #5 clk = ~clk;

  task automatic send(input logic [63:0] opnd, input logic dbl, input logic lng,
                      input logic [2:0] op, input logic [1:0] rm, input logic n08,
                      input logic [63:0] e_res, input logic e_inv, input logic e_inx,
                      input string tag);
    exp_t e;
    @(negedge clk);
    operand_i = opnd; dbl_i = dbl; long_i = lng; op_i = op; rmode_i = rm; nan2008_i = n08;
    valid_i = 1'b1;
    e.res = e_res; e.inv = e_inv; e.inx = e_inx; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected valid_o, result=%h", result_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (result_o !== e.res || invalid_o !== e.inv || inexact_o !== e.inx) begin
          errors++;
          $display("FAIL %s: result=%h inv=%b inx=%b expected result=%h inv=%b inx=%b",
                   e.tag, result_o, invalid_o, inexact_o, e.res, e.inv, e.inx);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: valid=%b result=%h inv=%b inx=%b expected 0 0 0 0",
               valid_o, result_o, invalid_o, inexact_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 round to nearest, ties to even
    send(D_2P5,  1, 0, 3'd2, 2'd0, 1, 64'd2, 0, 1, "R3 2.5 round");
    send(D_1P5,  1, 0, 3'd2, 2'd0, 1, 64'd2, 0, 1, "R3 1.5 round");
    send(D_M2P5, 1, 0, 3'd2, 2'd0, 1, -64'sd2, 0, 1, "R3 -2.5 round");
    send(64'h0000_0000_4060_0000, 0, 0, 3'd2, 2'd0, 1, 64'd4, 0, 1, "R3 3.5f round");
    // R2 directed operations
    send(D_2P5,  1, 0, 3'd0, 2'd0, 1, 64'd3, 0, 1, "R2 2.5 ceil");
    send(D_2P5,  1, 0, 3'd1, 2'd0, 1, 64'd2, 0, 1, "R2 2.5 floor");
    send(D_2P5,  1, 0, 3'd3, 2'd0, 1, 64'd2, 0, 1, "R2 2.5 trunc");
    send(D_M2P5, 1, 0, 3'd0, 2'd0, 1, -64'sd2, 0, 1, "R2 -2.5 ceil");
    send(D_M2P5, 1, 0, 3'd1, 2'd0, 1, -64'sd3, 0, 1, "R2 -2.5 floor");
    send(D_M2P5, 1, 0, 3'd3, 2'd0, 1, -64'sd2, 0, 1, "R2 -2.5 trunc");
    send(D_M2P5, 1, 0, 3'd6, 2'd2, 1, -64'sd2, 0, 1, "R2 -2.5 op6 as trunc");
    // R3 convert by rmode_i
    send(D_M1P5, 1, 0, 3'd4, 2'd0, 1, -64'sd2, 0, 1, "R3 cvt nearest");
    send(D_M1P5, 1, 0, 3'd4, 2'd1, 1, -64'sd1, 0, 1, "R3 cvt zero");
    send(D_M1P5, 1, 0, 3'd4, 2'd2, 1, -64'sd1, 0, 1, "R3 cvt up");
    send(D_M1P5, 1, 0, 3'd4, 2'd3, 1, -64'sd2, 0, 1, "R3 cvt down");
    send(64'h0000_0000_4020_0000, 0, 0, 3'd4, 2'd0, 0, 64'd2, 0, 1, "R3 2.5f cvt nearest");
    // R1 formats and widths
    send(64'hFFFF_FFFF_BFE0_0000, 0, 1, 3'd2, 2'd0, 1, -64'sd2, 0, 1, "R1 -1.75f long round");
    send(64'h0000_0000_BFE0_0000, 0, 1, 3'd0, 2'd0, 1, -64'sd1, 0, 1, "R1 -1.75f long ceil");
    send(64'h0000_0000_5380_0000, 0, 1, 3'd3, 2'd0, 1, 64'h0000_0100_0000_0000, 0, 0, "R1 2^40f long");
    // R5/R6 word overflow from a single operand
    send(64'h0000_0000_5380_0000, 0, 0, 3'd3, 2'd0, 1, MAXW, 1, 0, "R5 2^40f word 2008");
    send(64'h0000_0000_5380_0000, 0, 0, 3'd3, 2'd0, 0, MAXW, 1, 0, "R6 2^40f word legacy");
    send(64'h0000_0000_D380_0000, 0, 0, 3'd3, 2'd0, 1, MINW, 1, 0, "R5 -2^40f word 2008");
    send(64'h0000_0000_D380_0000, 0, 0, 3'd3, 2'd0, 0, MAXW, 1, 0, "R6 -2^40f word legacy");
    // R8 exact and inexact
    send(D_100,  1, 0, 3'd3, 2'd0, 1, 64'd100, 0, 0, "R8 100 exact");
    send(D_0P5,  1, 0, 3'd2, 2'd0, 1, 64'd0, 0, 1, "R8 0.5 round to 0");
    send(D_M0P5, 1, 0, 3'd0, 2'd0, 1, 64'd0, 0, 1, "R8 -0.5 ceil to 0");
    send(64'h0000_0000_0000_0001, 0, 0, 3'd0, 2'd0, 1, 64'd1, 0, 1, "R8 subnormal ceil");
    send(64'h0000_0000_0000_0001, 0, 0, 3'd1, 2'd0, 1, 64'd0, 0, 1, "R8 subnormal floor");
    send(64'h0000_0000_8000_0001, 0, 0, 3'd1, 2'd0, 1, -64'sd1, 0, 1, "R8 -subnormal floor");
    send(64'd0,   1, 0, 3'd2, 2'd0, 1, 64'd0, 0, 0, "R8 zero");
    send(D_MZERO, 1, 1, 3'd3, 2'd0, 0, 64'd0, 0, 0, "R8 minus zero long");
    // R4/R6 NaN
    send(D_NAN, 1, 0, 3'd2, 2'd0, 1, 64'd0, 1, 0, "R4 nan word 2008");
    send(64'h0000_0000_7FC0_0000, 0, 1, 3'd3, 2'd0, 1, 64'd0, 1, 0, "R4 nanf long 2008");
    send(D_NAN, 1, 0, 3'd2, 2'd0, 0, MAXW, 1, 0, "R6 nan word legacy");
    send(D_NAN, 1, 1, 3'd2, 2'd0, 0, MAXL, 1, 0, "R6 nan long legacy");
    // R5/R6 infinities
    send(D_MINF, 1, 0, 3'd3, 2'd0, 1, MINW, 1, 0, "R5 -inf word 2008");
    send(D_MINF, 1, 0, 3'd3, 2'd0, 0, MAXW, 1, 0, "R6 -inf word legacy");
    send(D_PINF, 1, 1, 3'd3, 2'd0, 1, MAXL, 1, 0, "R5 +inf long 2008");
    send(64'h0000_0000_FF80_0000, 0, 1, 3'd3, 2'd0, 0, MAXL, 1, 0, "R6 -inff long legacy");
    // R5 range limits
    send(D_M31, 1, 0, 3'd3, 2'd0, 1, MINW, 0, 0, "R5 -2^31 word in range");
    send(D_P31, 1, 0, 3'd3, 2'd0, 1, MAXW, 1, 0, "R5 2^31 word 2008");
    send(D_P31, 1, 0, 3'd3, 2'd0, 0, MAXW, 1, 0, "R6 2^31 word legacy");
    send(D_M63, 1, 1, 3'd3, 2'd0, 1, MINL, 0, 0, "R5 -2^63 long in range");
    send(D_M63, 1, 1, 3'd3, 2'd0, 0, MINL, 0, 0, "R6 -2^63 long legacy in range");
    send(D_P63, 1, 1, 3'd3, 2'd0, 1, MAXL, 1, 0, "R5 2^63 long 2008");
    send(D_M63, 1, 0, 3'd3, 2'd0, 1, MINW, 1, 0, "R5 -2^63 word 2008");
    send(D_M63, 1, 0, 3'd3, 2'd0, 0, MAXW, 1, 0, "R6 -2^63 word legacy");
    // R7 overflow judged after rounding
    send(D_EDGE, 1, 0, 3'd2, 2'd0, 1, MAXW, 1, 0, "R7 2^31-0.5 round overflows");
    send(D_EDGE, 1, 0, 3'd3, 2'd0, 1, MAXW, 0, 1, "R7 2^31-0.5 trunc in range");
    send(D_100,  1, 0, 3'd3, 2'd0, 1, 64'd100, 0, 0, "R9 last before idle");

    // R9 idle: inputs change with valid_i low, outputs must hold
    @(negedge clk);
    valid_i = 1'b0;
    operand_i = D_NAN; nan2008_i = 1'b0; long_i = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== 64'd100 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 hold: valid=%b result=%h inv=%b inx=%b expected 0 %h 0 0",
               valid_o, result_o, invalid_o, inexact_o, 64'd100);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing results: pending=%0d expected 0", exp_q.size());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule